// File: doc/BRIEF.md
# Counter-Style Trim Position Register with Nonvolatile Store

This block holds a 7-bit trim code that feeds a downstream converter. A host adjusts the code through three wires: an active-low select, a strobe whose falling edge requests one step, and a direction level. Each accepted strobe edge moves the code one position up or down. The code saturates at both ends.

When the host releases select, the block decides whether to keep the setting. If the strobe is high at that moment, the current code is written to a nonvolatile memory. If the strobe is low, the memory is left as it was, so the older setting comes back after the next power cycle. A write is requested only when the code differs from the value last stored or recalled. After reset, the block reads the memory and loads the code from it before it accepts any adjustment.

Both memory transfers use a request that is held until an acknowledge. A busy output covers the recall and any write. The three host inputs are asynchronous. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies.

Top module: `updown_trim`

## Requirements
- R1: While rst_n is low, busy is 1, code is 0 and mem_rd_req is 1. Strobe or select activity that reaches the block before the recall completes causes no step and no write.
- R2: With select low (sel_n = 0), each high-to-low transition of stb moves code by exactly one position.
- R3: If dir_up is 1 at the strobe edge, code increases by one. If dir_up is 0, code decreases by one.
- R4: code stays at 127 when stepped up and stays at 0 when stepped down. It never wraps.
- R5: A low-to-high transition of sel_n while stb is high raises mem_wr_req with mem_wr_data equal to code. Both stay unchanged until mem_wr_ack, and after the ack the memory holds the new code.
- R6: A low-to-high transition of sel_n while stb is low issues no write. The previously stored code is recalled after the next reset.
- R7: After reset, mem_rd_req stays high until mem_rd_ack. On the ack, code takes the value of mem_rd_data and busy falls.
- R8: While sel_n is high, strobe transitions leave code unchanged.
- R9: busy is 1 from the cycle a write is requested until the cycle after mem_wr_ack. Strobe edges that arrive in that window are dropped.
- R10: Releasing select with stb high issues no write when code equals the value last stored or recalled.
- R11: An input change that comes before rising clock edge j shows up on code, busy or mem_wr_req right after edge j+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| sel_n | input | 1 | Active-low select, asynchronous |
| stb | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| dir_up | input | 1 | Step direction, 1 = up, asynchronous |
| code | output | 7 | Current trim code |
| busy | output | 1 | Recall or write in progress |
| mem_rd_req | output | 1 | Read request to the nonvolatile memory |
| mem_rd_data | input | 7 | Data returned by the memory |
| mem_rd_ack | input | 1 | One-cycle read acknowledge |
| mem_wr_req | output | 1 | Write request to the nonvolatile memory |
| mem_wr_data | output | 7 | Code to be written |
| mem_wr_ack | input | 1 | One-cycle write acknowledge |

## Verification
A change on a host input appears on code or busy after the third rising clock edge. That is two synchronizer flops plus the edge-history flop, with the state register loaded on that same edge. The bench's reference model keeps a three-deep history of each input and acts on the two oldest entries, so it predicts the exact cycle, and it is compared with code and busy on every falling clock edge. Memory acknowledges come from the bench's own memory model. The model reads them on the same edge the design does, so write and recall completion line up to the cycle. A directed check samples code on the first three falling edges after a strobe fall, and expects the old value twice and the new one on the third.

// File: rtl/updown_trim.sv
module updown_trim #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         stb,
  input  logic         dir_up,
  output logic [W-1:0] code,
  output logic         busy,
  output logic         mem_rd_req,
  input  logic [W-1:0] mem_rd_data,
  input  logic         mem_rd_ack,
  output logic         mem_wr_req,
  output logic [W-1:0] mem_wr_data,
  input  logic         mem_wr_ack
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  typedef enum logic [1:0] {S_RECALL, S_IDLE, S_WRITE} st_t;

  st_t          st;
  logic [W-1:0] code_q, saved_q;
  logic [2:0]   sel_h, stb_h, dir_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_h <= 3'b111;
      stb_h <= 3'b111;
      dir_h <= 3'b000;
    end else begin
      sel_h <= {sel_h[1:0], sel_n};
      stb_h <= {stb_h[1:0], stb};
      dir_h <= {dir_h[1:0], dir_up};
    end
  end

  wire stb_fall = stb_h[2] & ~stb_h[1];
  wire sel_rise = ~sel_h[2] & sel_h[1];
  wire idle     = (st == S_IDLE);
  wire do_step  = idle & stb_fall & ~sel_h[1];
  wire do_store = idle & sel_rise & stb_h[1] & (code_q != saved_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RECALL;
      code_q  <= BOT;
      saved_q <= BOT;
    end else begin
      case (st)
        S_RECALL: if (mem_rd_ack) begin
          code_q  <= mem_rd_data;
          saved_q <= mem_rd_data;
          st      <= S_IDLE;
        end
        S_IDLE: begin
          if (do_step) begin
            if (dir_h[1] && code_q != TOP)       code_q <= code_q + 1'b1;
            else if (!dir_h[1] && code_q != BOT) code_q <= code_q - 1'b1;
          end
          if (do_store) st <= S_WRITE;
        end
        S_WRITE: if (mem_wr_ack) begin
          saved_q <= code_q;
          st      <= S_IDLE;
        end
        default: st <= S_RECALL;
      endcase
    end
  end

  assign code        = code_q;
  assign busy        = !idle;
  assign mem_rd_req  = (st == S_RECALL);
  assign mem_wr_req  = (st == S_WRITE);
  assign mem_wr_data = code_q;

  a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (code == $past(code) || code == $past(code) + 1'b1 || code == $past(code) - 1'b1));

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && code == TOP) |=> (code == TOP || code == TOP - 1'b1));

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data)));

  a_r8_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sel_h[1] && sel_h[2]) |=> $stable(code));

  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRITE) |=> $stable(code));

  a_r10_no_redundant_store: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_req) |-> (mem_wr_data != saved_q));
endmodule

// File: tb/updown_trim_tb.sv
module updown_trim_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RD_LAT = 6;
  localparam int WR_LAT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, stb = 1'b1, dir_up = 1'b0;
  logic [6:0] code, mem_rd_data, mem_wr_data;
  logic busy, mem_rd_req, mem_rd_ack, mem_wr_req, mem_wr_ack;

  int checks = 0, fails = 0, cyc = 0, wr_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_trim u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .stb(stb), .dir_up(dir_up),
    .code(code), .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_data(mem_rd_data),
    .mem_rd_ack(mem_rd_ack), .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack)
  );

  logic [6:0] nv_val = 7'd100;
  int mcnt = 0;
  assign mem_rd_data = nv_val;
  initial begin mem_rd_ack = 1'b0; mem_wr_ack = 1'b0; end

  always @(posedge clk) begin
    mem_rd_ack <= 1'b0;
    mem_wr_ack <= 1'b0;
    if (!rst_n) mcnt <= 0;
    else if (mem_rd_req && !mem_rd_ack) begin
      if (mcnt == RD_LAT) begin mem_rd_ack <= 1'b1; mcnt <= 0; end
      else mcnt <= mcnt + 1;
    end else if (mem_wr_req && !mem_wr_ack) begin
      if (mcnt == WR_LAT) begin
        mem_wr_ack <= 1'b1; mcnt <= 0; nv_val <= mem_wr_data; wr_count <= wr_count + 1;
      end else mcnt <= mcnt + 1;
    end
  end

  // reference model: 0 recall, 1 idle, 2 write
  int m_st = 0, m_code = 0, m_saved = 0;
  bit hs[3], ht[3], hd[3];
  initial for (int i = 0; i < 3; i++) begin hs[i] = 1; ht[i] = 1; hd[i] = 0; end

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_code = 0; m_saved = 0;
      for (int i = 0; i < 3; i++) begin hs[i] = 1; ht[i] = 1; hd[i] = 0; end
    end else begin
      if (m_st == 0) begin
        if (mem_rd_ack) begin m_code = int'(nv_val); m_saved = m_code; m_st = 1; end
      end else if (m_st == 1) begin
        if (ht[2] && !ht[1] && !hs[1]) begin
          if (hd[1]) m_code = (m_code < 127) ? m_code + 1 : 127;
          else       m_code = (m_code > 0) ? m_code - 1 : 0;
        end
        if (!hs[2] && hs[1] && ht[1] && m_code != m_saved) m_st = 2;
      end else if (mem_wr_ack) begin
        m_saved = m_code; m_st = 1;
      end
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = sel_n;
      ht[2] = ht[1]; ht[1] = ht[0]; ht[0] = stb;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = dir_up;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    check(int'(code) == m_code, "R2/R3/R11 code vs model", int'(code), m_code);
    check(busy == (m_st != 1), "R9 busy vs model", int'(busy), int'(m_st != 1));
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      stb = 1'b0; cycles(4);
      stb = 1'b1; cycles(4);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  int old, wc;

  initial begin
    @(negedge clk);
    check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    check(code == 7'd0, "R1 code in reset", int'(code), 0);
    check(mem_rd_req == 1'b1, "R1 read request in reset", int'(mem_rd_req), 1);
    sel_n = 1'b0; stb = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    wait_idle();
    cycles(2);
    check(int'(code) == 100, "R1 R7 recall without stray step", int'(code), 100);

    stb = 1'b1; dir_up = 1'b1; cycles(4);
    pulse(3);
    check(int'(code) == 103, "R2 R3 three up steps", int'(code), 103);

    old = int'(code);
    stb = 1'b0;
    @(negedge clk); check(int'(code) == old, "R11 no change after edge j", int'(code), old);
    @(negedge clk); check(int'(code) == old, "R11 no change after edge j+1", int'(code), old);
    @(negedge clk); check(int'(code) == old + 1, "R11 change after edge j+2", int'(code), old + 1);
    stb = 1'b1; cycles(4);

    dir_up = 1'b0; pulse(5);
    check(int'(code) == 99, "R3 five down steps", int'(code), 99);

    wc = wr_count;
    sel_n = 1'b1; cycles(4);
    check(busy == 1'b1 && mem_wr_req == 1'b1, "R5 write requested", int'(mem_wr_req), 1);
    check(int'(mem_wr_data) == 99, "R5 write data", int'(mem_wr_data), 99);
    sel_n = 1'b0; cycles(1);
    pulse(1);
    wait_idle(); cycles(2);
    check(int'(nv_val) == 99, "R5 memory holds stored code", int'(nv_val), 99);
    check(wr_count == wc + 1, "R5 one write", wr_count, wc + 1);
    check(int'(code) == 99, "R9 step during write dropped", int'(code), 99);

    sel_n = 1'b1; cycles(8);
    check(wr_count == wc + 1, "R10 unchanged code not written", wr_count, wc + 1);
    check(busy == 1'b0, "R10 busy stays low", int'(busy), 0);

    dir_up = 1'b1; pulse(4);
    check(int'(code) == 99, "R8 standby ignores strobe", int'(code), 99);

    sel_n = 1'b0; cycles(2);
    pulse(40);
    check(int'(code) == 127, "R4 saturate at top", int'(code), 127);
    dir_up = 1'b0; pulse(130);
    check(int'(code) == 0, "R4 saturate at bottom", int'(code), 0);

    wc = wr_count;
    stb = 1'b0; cycles(4);
    sel_n = 1'b1; cycles(6);
    check(wr_count == wc, "R6 no write with strobe low", wr_count, wc);
    check(busy == 1'b0, "R6 no busy on discard", int'(busy), 0);
    stb = 1'b1; cycles(4);
    check(int'(nv_val) == 99, "R6 memory unchanged", int'(nv_val), 99);

    rst_n = 1'b0; cycles(3);
    rst_n = 1'b1;
    wait_idle(); cycles(2);
    check(int'(code) == 99, "R6 R7 old code recalled", int'(code), 99);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule